// File: doc/BRIEF.md
# Per-Type Warp Issue Dispatcher

This block sits between the warp instruction buffers and a pool of execution units of several kinds. Each warp slot presents at most one decoded instruction at a time: a request flag, the kind of unit it needs, an opcode, two source operand values and an immediate. Each execution unit reports a fixed kind code, a flag saying it can take a new task on the next cycle, and the ID of the warp whose task it will release next. A unit may be pipelined and take a new warp every cycle, so its stages can hold different warps.

In every cycle the dispatcher matches requesting warps to free units of the kind they ask for. Within one kind, the warp with the lower ID always wins. If several units of that kind are free, that many warps can issue in the same cycle, each to its own unit. The grant goes back to the warps in the same cycle. The issued task appears on the chosen unit's input registers on the next cycle. A companion return path, the arranger, takes each unit's completion and sends it back to the slot of the warp named by that unit's release ID.

Top module: `warp_issue_dispatcher`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, no unit sees an issue strobe and no warp sees a completion strobe.
- R2: A warp is granted only when it requests and a free unit of its requested kind exists. The number of warps granted for a kind never exceeds the number of free units of that kind in that cycle.
- R3: Among warps that request the same kind, a warp is never passed over while a warp with a higher ID is granted for that kind.
- R4: When N units of one kind are free, min(N, requesters) warps of that kind are granted in the same cycle, each to a different unit. Warps that want different kinds are served in the same cycle.
- R5: Within one kind, the free units are filled in ascending unit index, paired with the granted warps in ascending warp ID.
- R6: One cycle after a grant, the chosen unit sees its issue strobe together with the granted warp's ID, opcode, first and second source values and immediate, as they were in the grant cycle.
- R7: A unit that is not free, or whose kind differs from every request, sees no issue strobe on the next cycle.
- R8: Kind codes are 3 bits: 0 thread indexing, 1 branch, 2 memory, 3 integer, 4 floating point, 5 slow function, 6 ray. Code 7 matches no unit in use, and a request carrying it is never granted.
- R9: A unit that signals completion sends its result data to the warp slot named by its release ID, with a completion strobe on the next cycle. Completions for different warps are delivered in parallel. If two units name the same warp, the lower unit index wins.
- R10: A warp that is not granted keeps its request, and it is granted as soon as a matching unit is free. A pipelined unit that stays free accepts a different warp on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | NUM_WARPS | Per-warp issue request |
| reqKind | input | NUM_WARPS x KIND_W | Requested unit kind per warp |
| reqOp | input | NUM_WARPS x OP_W | Opcode per warp |
| reqRs | input | NUM_WARPS x DATA_W | First source operand per warp |
| reqRt | input | NUM_WARPS x DATA_W | Second source operand per warp |
| reqImm | input | NUM_WARPS x IMM_W | Immediate per warp |
| grant | output | NUM_WARPS | Per-warp grant, same cycle |
| unitKind | input | NUM_UNITS x KIND_W | Fixed kind code of each unit |
| unitFree | input | NUM_UNITS | Unit can accept a task next cycle |
| unitRelWarp | input | NUM_UNITS x WID_W | Warp whose task the unit will release |
| unitDone | input | NUM_UNITS | Unit completion strobe |
| unitResult | input | NUM_UNITS x DATA_W | Unit result data |
| issueValid | output | NUM_UNITS | Issue strobe per unit |
| issueWarp | output | NUM_UNITS x WID_W | Warp ID of the issued task |
| issueOp | output | NUM_UNITS x OP_W | Issued opcode |
| issueRs | output | NUM_UNITS x DATA_W | Issued first source value |
| issueRt | output | NUM_UNITS x DATA_W | Issued second source value |
| issueImm | output | NUM_UNITS x IMM_W | Issued immediate |
| wbValid | output | NUM_WARPS | Completion strobe per warp slot |
| wbData | output | NUM_WARPS x DATA_W | Completion data per warp slot |

## Verification
The assertions check several rules on every cycle: a grant is never given without a request, no lower-ID warp is passed over for a higher-ID warp of the same kind, issue strobes land only on units that were free, the number of issue strobes matches the grants of the cycle before, the issued kind and payload match the grant cycle, and every completion strobe has a matching unit completion behind it. The directed scenarios show what a per-cycle property cannot pin down: the exact pairing of units to warps in ascending order, that a request of kind 7 is dropped, that a held request is served on a later cycle through a pipelined unit, and that the lower unit wins when two completions name one warp.

// File: rtl/warp_issue_pkg.sv
package warp_issue_pkg;
  localparam int unsigned KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_THREADIDX = 3'd0,
    KIND_BRANCH    = 3'd1,
    KIND_MEMORY    = 3'd2,
    KIND_INTEGER   = 3'd3,
    KIND_FLOAT     = 3'd4,
    KIND_SLOWFN    = 3'd5,
    KIND_RAY       = 3'd6,
    KIND_NONE      = 3'd7
  } unitKind_e;
endpackage

// File: rtl/warp_issue_ctl.sv
module warp_issue_ctl
  import warp_issue_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned NUM_UNITS = 6,
  localparam int unsigned WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic [NUM_WARPS-1:0]             reqValid,
  input  logic [NUM_WARPS-1:0][KIND_W-1:0] reqKind,
  input  logic [NUM_UNITS-1:0][KIND_W-1:0] unitKind,
  input  logic [NUM_UNITS-1:0]             unitFree,
  output logic [NUM_WARPS-1:0]             grant,
  output logic [NUM_UNITS-1:0]             strobeSel,
  output logic [NUM_UNITS-1:0][WID_W-1:0]  strobeWarp
);
  // Units are visited in ascending index. Each unit takes the lowest-ID
  // warp of its kind that no lower unit has taken yet.
  logic [NUM_WARPS-1:0] taken;
  logic                 found;

  always_comb begin
    taken      = '0;
    strobeSel  = '0;
    strobeWarp = '0;
    found      = 1'b0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      found = 1'b0;
      if (unitFree[u]) begin
        for (int w = 0; w < NUM_WARPS; w++) begin
          if (!found && reqValid[w] && !taken[w] && (reqKind[w] == unitKind[u])) begin
            found         = 1'b1;
            taken[w]      = 1'b1;
            strobeSel[u]  = 1'b1;
            strobeWarp[u] = WID_W'(w);
          end
        end
      end
    end
    grant = taken;
  end
endmodule

// File: rtl/warp_issue_dp.sv
module warp_issue_dp
  import warp_issue_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned NUM_UNITS = 6,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned OP_W      = 8,
  parameter int unsigned IMM_W     = 16,
  localparam int unsigned WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_WARPS-1:0][OP_W-1:0]   reqOp,
  input  logic [NUM_WARPS-1:0][DATA_W-1:0] reqRs,
  input  logic [NUM_WARPS-1:0][DATA_W-1:0] reqRt,
  input  logic [NUM_WARPS-1:0][IMM_W-1:0]  reqImm,
  input  logic [NUM_UNITS-1:0]             strobeSel,
  input  logic [NUM_UNITS-1:0][WID_W-1:0]  strobeWarp,
  input  logic [NUM_UNITS-1:0][WID_W-1:0]  unitRelWarp,
  input  logic [NUM_UNITS-1:0]             unitDone,
  input  logic [NUM_UNITS-1:0][DATA_W-1:0] unitResult,
  output logic [NUM_UNITS-1:0]             issueValid,
  output logic [NUM_UNITS-1:0][WID_W-1:0]  issueWarp,
  output logic [NUM_UNITS-1:0][OP_W-1:0]   issueOp,
  output logic [NUM_UNITS-1:0][DATA_W-1:0] issueRs,
  output logic [NUM_UNITS-1:0][DATA_W-1:0] issueRt,
  output logic [NUM_UNITS-1:0][IMM_W-1:0]  issueImm,
  output logic [NUM_WARPS-1:0]             wbValid,
  output logic [NUM_WARPS-1:0][DATA_W-1:0] wbData
);
  // Issue registers, one lane per unit
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        issueValid[u] <= 1'b0;
        issueWarp[u]  <= '0;
        issueOp[u]    <= '0;
        issueRs[u]    <= '0;
        issueRt[u]    <= '0;
        issueImm[u]   <= '0;
      end else begin
        issueValid[u] <= strobeSel[u];
        if (strobeSel[u]) begin
          issueWarp[u] <= strobeWarp[u];
          issueOp[u]   <= reqOp[strobeWarp[u]];
          issueRs[u]   <= reqRs[strobeWarp[u]];
          issueRt[u]   <= reqRt[strobeWarp[u]];
          issueImm[u]  <= reqImm[strobeWarp[u]];
        end
      end
    end
  end

  // Arranger: route completions to warp slots, lower unit wins on a clash
  logic [NUM_WARPS-1:0]             nxtValid;
  logic [NUM_WARPS-1:0][DATA_W-1:0] nxtData;

  always_comb begin
    nxtValid = '0;
    nxtData  = '0;
    for (int u = NUM_UNITS - 1; u >= 0; u--) begin
      if (unitDone[u]) begin
        nxtValid[unitRelWarp[u]] = 1'b1;
        nxtData[unitRelWarp[u]]  = unitResult[u];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbValid <= '0;
      wbData  <= '0;
    end else begin
      wbValid <= nxtValid;
      wbData  <= nxtData;
    end
  end
endmodule

// File: rtl/warp_issue_dispatcher.sv
module warp_issue_dispatcher
  import warp_issue_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned NUM_UNITS = 6,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned OP_W      = 8,
  parameter int unsigned IMM_W     = 16,
  localparam int unsigned WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_WARPS-1:0]             reqValid,
  input  logic [NUM_WARPS-1:0][KIND_W-1:0] reqKind,
  input  logic [NUM_WARPS-1:0][OP_W-1:0]   reqOp,
  input  logic [NUM_WARPS-1:0][DATA_W-1:0] reqRs,
  input  logic [NUM_WARPS-1:0][DATA_W-1:0] reqRt,
  input  logic [NUM_WARPS-1:0][IMM_W-1:0]  reqImm,
  output logic [NUM_WARPS-1:0]             grant,
  input  logic [NUM_UNITS-1:0][KIND_W-1:0] unitKind,
  input  logic [NUM_UNITS-1:0]             unitFree,
  input  logic [NUM_UNITS-1:0][WID_W-1:0]  unitRelWarp,
  input  logic [NUM_UNITS-1:0]             unitDone,
  input  logic [NUM_UNITS-1:0][DATA_W-1:0] unitResult,
  output logic [NUM_UNITS-1:0]             issueValid,
  output logic [NUM_UNITS-1:0][WID_W-1:0]  issueWarp,
  output logic [NUM_UNITS-1:0][OP_W-1:0]   issueOp,
  output logic [NUM_UNITS-1:0][DATA_W-1:0] issueRs,
  output logic [NUM_UNITS-1:0][DATA_W-1:0] issueRt,
  output logic [NUM_UNITS-1:0][IMM_W-1:0]  issueImm,
  output logic [NUM_WARPS-1:0]             wbValid,
  output logic [NUM_WARPS-1:0][DATA_W-1:0] wbData
);
  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_UNITS-1:0]            sel;
    logic [NUM_UNITS-1:0][WID_W-1:0] warp;
  } issueStrobe_t;

  issueStrobe_t strobe;

  warp_issue_ctl #(
    .NUM_WARPS(NUM_WARPS),
    .NUM_UNITS(NUM_UNITS)
  ) ctl_i (
    .reqValid  (reqValid),
    .reqKind   (reqKind),
    .unitKind  (unitKind),
    .unitFree  (unitFree),
    .grant     (grant),
    .strobeSel (strobe.sel),
    .strobeWarp(strobe.warp)
  );

  warp_issue_dp #(
    .NUM_WARPS(NUM_WARPS),
    .NUM_UNITS(NUM_UNITS),
    .DATA_W   (DATA_W),
    .OP_W     (OP_W),
    .IMM_W    (IMM_W)
  ) dp_i (
    .clk        (clk),
    .rst        (rst),
    .reqOp      (reqOp),
    .reqRs      (reqRs),
    .reqRt      (reqRt),
    .reqImm     (reqImm),
    .strobeSel  (strobe.sel),
    .strobeWarp (strobe.warp),
    .unitRelWarp(unitRelWarp),
    .unitDone   (unitDone),
    .unitResult (unitResult),
    .issueValid (issueValid),
    .issueWarp  (issueWarp),
    .issueOp    (issueOp),
    .issueRs    (issueRs),
    .issueRt    (issueRt),
    .issueImm   (issueImm),
    .wbValid    (wbValid),
    .wbData     (wbData)
  );
endmodule

// File: rtl/warp_issue_dispatcher_chk.sv
module warp_issue_dispatcher_chk
  import warp_issue_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 8,
  parameter int unsigned NUM_UNITS = 6,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned OP_W      = 8,
  parameter int unsigned IMM_W     = 16,
  localparam int unsigned WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input logic                             clk,
  input logic                             rst,
  input logic [NUM_WARPS-1:0]             reqValid,
  input logic [NUM_WARPS-1:0][KIND_W-1:0] reqKind,
  input logic [NUM_WARPS-1:0][OP_W-1:0]   reqOp,
  input logic [NUM_WARPS-1:0][DATA_W-1:0] reqRs,
  input logic [NUM_WARPS-1:0][DATA_W-1:0] reqRt,
  input logic [NUM_WARPS-1:0][IMM_W-1:0]  reqImm,
  input logic [NUM_WARPS-1:0]             grant,
  input logic [NUM_UNITS-1:0][KIND_W-1:0] unitKind,
  input logic [NUM_UNITS-1:0]             unitFree,
  input logic [NUM_UNITS-1:0][WID_W-1:0]  unitRelWarp,
  input logic [NUM_UNITS-1:0]             unitDone,
  input logic [NUM_UNITS-1:0][DATA_W-1:0] unitResult,
  input logic [NUM_UNITS-1:0]             issueValid,
  input logic [NUM_UNITS-1:0][WID_W-1:0]  issueWarp,
  input logic [NUM_UNITS-1:0][OP_W-1:0]   issueOp,
  input logic [NUM_UNITS-1:0][DATA_W-1:0] issueRs,
  input logic [NUM_UNITS-1:0][DATA_W-1:0] issueRt,
  input logic [NUM_UNITS-1:0][IMM_W-1:0]  issueImm,
  input logic [NUM_WARPS-1:0]             wbValid,
  input logic [NUM_WARPS-1:0][DATA_W-1:0] wbData
);
  // Grant-cycle copies of the request side
  logic [NUM_WARPS-1:0][KIND_W-1:0] prevKind;
  logic [NUM_WARPS-1:0][OP_W-1:0]   prevOp;
  logic [NUM_WARPS-1:0][DATA_W-1:0] prevRs;
  logic [NUM_WARPS-1:0][DATA_W-1:0] prevRt;
  logic [NUM_WARPS-1:0][IMM_W-1:0]  prevImm;
  logic [NUM_UNITS-1:0][KIND_W-1:0] prevUnitKind;
  logic [NUM_WARPS-1:0]             doneFor;

  always_ff @(posedge clk) begin
    prevKind     <= reqKind;
    prevOp       <= reqOp;
    prevRs       <= reqRs;
    prevRt       <= reqRt;
    prevImm      <= reqImm;
    prevUnitKind <= unitKind;
  end

  always_comb begin
    doneFor = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (unitDone[u]) doneFor[unitRelWarp[u]] = 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (issueValid == '0 && wbValid == '0));

  // R4
  issue_count_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(issueValid) == $past($countones(grant))));

  // R9
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    // R2
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
      grant[w] |-> reqValid[w]);
    // R9
    wb_has_source_chk: assert property (@(posedge clk) disable iff (rst)
      wbValid[w] |-> $past(doneFor[w]));
    for (genvar v = w + 1; v < NUM_WARPS; v++) begin : g_pair
      // R3
      priority_order_chk: assert property (@(posedge clk) disable iff (rst)
        !(reqValid[w] && !grant[w] && grant[v] && reqKind[w] == reqKind[v]));
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    // R7
    issue_only_free_chk: assert property (@(posedge clk) disable iff (rst)
      issueValid[u] |-> $past(unitFree[u]));
    // R7
    issue_kind_match_chk: assert property (@(posedge clk) disable iff (rst)
      issueValid[u] |-> (prevKind[issueWarp[u]] == prevUnitKind[u]));
    // R6
    issue_payload_chk: assert property (@(posedge clk) disable iff (rst)
      issueValid[u] |-> (issueOp[u] == prevOp[issueWarp[u]] &&
                         issueRs[u] == prevRs[issueWarp[u]] &&
                         issueRt[u] == prevRt[issueWarp[u]] &&
                         issueImm[u] == prevImm[issueWarp[u]]));
  end
endmodule

bind warp_issue_dispatcher warp_issue_dispatcher_chk #(
  .NUM_WARPS(NUM_WARPS),
  .NUM_UNITS(NUM_UNITS),
  .DATA_W   (DATA_W),
  .OP_W     (OP_W),
  .IMM_W    (IMM_W)
) chk_i (.*);

// File: tb/warp_issue_dispatcher_tb_top.sv
module warp_issue_dispatcher_tb_top;
  import warp_issue_pkg::*;

  localparam int unsigned NW = 8;
  localparam int unsigned NU = 6;
  localparam int unsigned DW = 32;
  localparam int unsigned OW = 8;
  localparam int unsigned IW = 16;
  localparam int unsigned WW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [NW-1:0]             reqValid;
  logic [NW-1:0][KIND_W-1:0] reqKind;
  logic [NW-1:0][OW-1:0]     reqOp;
  logic [NW-1:0][DW-1:0]     reqRs;
  logic [NW-1:0][DW-1:0]     reqRt;
  logic [NW-1:0][IW-1:0]     reqImm;
  logic [NW-1:0]             grant;
  logic [NU-1:0][KIND_W-1:0] unitKind;
  logic [NU-1:0]             unitFree;
  logic [NU-1:0][WW-1:0]     unitRelWarp;
  logic [NU-1:0]             unitDone;
  logic [NU-1:0][DW-1:0]     unitResult;
  logic [NU-1:0]             issueValid;
  logic [NU-1:0][WW-1:0]     issueWarp;
  logic [NU-1:0][OW-1:0]     issueOp;
  logic [NU-1:0][DW-1:0]     issueRs;
  logic [NU-1:0][DW-1:0]     issueRt;
  logic [NU-1:0][IW-1:0]     issueImm;
  logic [NW-1:0]             wbValid;
  logic [NW-1:0][DW-1:0]     wbData;

  warp_issue_dispatcher #(
    .NUM_WARPS(NW), .NUM_UNITS(NU), .DATA_W(DW), .OP_W(OW), .IMM_W(IW)
  ) dut_i (.*);

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    reqValid = '0;
    reqKind  = '0;
    unitFree = '1;
    unitDone = '0;
    unitRelWarp = '0;
    unitResult  = '0;
  endtask

  // Checks the full issued task on unit u against warp w
  task automatic chkIssue(input string tag, input int u, input int w);
    chk({tag, " warp"}, 64'(issueWarp[u]), 64'(w));
    chk({tag, " op"},   64'(issueOp[u]),   64'(8'h10 + w));
    chk({tag, " rs"},   64'(issueRs[u]),   64'(32'hA000_0000 + w));
    chk({tag, " rt"},   64'(issueRt[u]),   64'(32'hB000_0000 + w));
    chk({tag, " imm"},  64'(issueImm[u]),  64'(16'h0C00 + w));
  endtask

  task automatic testReset();
    chk("R1 issue in reset", 64'(issueValid), 64'h0);
    chk("R1 wb in reset", 64'(wbValid), 64'h0);
    rst = 1'b0;
    tick();
    chk("R1 issue after reset", 64'(issueValid), 64'h0);
    chk("R1 wb after reset", 64'(wbValid), 64'h0);
  endtask

  task automatic testSingle();
    idle();
    reqValid[5] = 1'b1; reqKind[5] = KIND_INTEGER;
    #1;
    chk("R2 single grant", 64'(grant), 64'h20);
    tick();
    idle();
    chk("R6 single issue strobe", 64'(issueValid), 64'h01);
    chkIssue("R6 single", 0, 5);
  endtask

  task automatic testPriority();
    idle();
    unitFree = 6'b111101;
    reqValid[2] = 1'b1; reqKind[2] = KIND_INTEGER;
    reqValid[6] = 1'b1; reqKind[6] = KIND_INTEGER;
    #1;
    chk("R3 lower id wins", 64'(grant), 64'h04);
    tick();
    idle();
    chk("R3 issue strobe", 64'(issueValid), 64'h01);
    chk("R3 issued warp", 64'(issueWarp[0]), 64'd2);
  endtask

  task automatic testMulti();
    idle();
    reqValid[1] = 1'b1; reqKind[1] = KIND_INTEGER;
    reqValid[3] = 1'b1; reqKind[3] = KIND_INTEGER;
    reqValid[4] = 1'b1; reqKind[4] = KIND_INTEGER;
    #1;
    chk("R4 two of three granted", 64'(grant), 64'h0A);
    tick();
    idle();
    chk("R4 two units issued", 64'(issueValid), 64'h03);
    chkIssue("R5 unit0", 0, 1);
    chkIssue("R5 unit1", 1, 3);
  endtask

  task automatic testKinds();
    idle();
    reqValid[0] = 1'b1; reqKind[0] = KIND_NONE;
    reqValid[1] = 1'b1; reqKind[1] = KIND_FLOAT;
    reqValid[2] = 1'b1; reqKind[2] = KIND_RAY;
    #1;
    chk("R8 code 7 and ray dropped", 64'(grant), 64'h02);
    tick();
    idle();
    chk("R8 float to unit2", 64'(issueValid), 64'h04);
    chk("R8 float warp", 64'(issueWarp[2]), 64'd1);
  endtask

  task automatic testBusy();
    idle();
    unitFree = 6'b110111;
    reqValid[0] = 1'b1; reqKind[0] = KIND_MEMORY;
    #1;
    chk("R7 busy no grant", 64'(grant), 64'h0);
    tick();
    idle();
    chk("R7 busy no issue", 64'(issueValid), 64'h0);
  endtask

  task automatic testHold();
    idle();
    unitFree = 6'b000001;
    reqValid[0] = 1'b1; reqKind[0] = KIND_INTEGER;
    reqValid[1] = 1'b1; reqKind[1] = KIND_INTEGER;
    #1;
    chk("R10 first grant", 64'(grant), 64'h01);
    tick();
    reqValid[0] = 1'b0;
    #1;
    chk("R10 held warp granted", 64'(grant), 64'h02);
    chk("R10 first issue", 64'(issueWarp[0]), 64'd0);
    tick();
    idle();
    chk("R10 back to back strobe", 64'(issueValid), 64'h01);
    chkIssue("R10 second", 0, 1);
  endtask

  task automatic testMixed();
    idle();
    reqValid[0] = 1'b1; reqKind[0] = KIND_THREADIDX;
    reqValid[1] = 1'b1; reqKind[1] = KIND_BRANCH;
    reqValid[2] = 1'b1; reqKind[2] = KIND_MEMORY;
    reqValid[3] = 1'b1; reqKind[3] = KIND_INTEGER;
    reqValid[4] = 1'b1; reqKind[4] = KIND_FLOAT;
    #1;
    chk("R4 all kinds granted", 64'(grant), 64'h1F);
    tick();
    idle();
    chk("R4 mixed strobes", 64'(issueValid), 64'h3D);
    chk("R8 threadidx unit", 64'(issueWarp[5]), 64'd0);
    chk("R8 branch unit", 64'(issueWarp[4]), 64'd1);
    chk("R8 memory unit", 64'(issueWarp[3]), 64'd2);
    chk("R8 integer unit", 64'(issueWarp[0]), 64'd3);
  endtask

  task automatic testArranger();
    idle();
    unitDone[2] = 1'b1; unitRelWarp[2] = 3'd6; unitResult[2] = 32'h1111_6666;
    unitDone[4] = 1'b1; unitRelWarp[4] = 3'd1; unitResult[4] = 32'h2222_1111;
    tick();
    idle();
    chk("R9 parallel strobes", 64'(wbValid), 64'h42);
    chk("R9 warp6 data", 64'(wbData[6]), 64'h1111_6666);
    chk("R9 warp1 data", 64'(wbData[1]), 64'h2222_1111);
    unitDone[0] = 1'b1; unitRelWarp[0] = 3'd2; unitResult[0] = 32'hAAAA_0000;
    unitDone[3] = 1'b1; unitRelWarp[3] = 3'd2; unitResult[3] = 32'hBBBB_0003;
    tick();
    idle();
    chk("R9 clash strobe", 64'(wbValid), 64'h04);
    chk("R9 lower unit wins", 64'(wbData[2]), 64'hAAAA_0000);
    tick();
    chk("R9 strobe clears", 64'(wbValid), 64'h0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int w = 0; w < NW; w++) begin
      reqOp[w]  = OW'(8'h10 + w);
      reqRs[w]  = 32'hA000_0000 + 32'(w);
      reqRt[w]  = 32'hB000_0000 + 32'(w);
      reqImm[w] = 16'h0C00 + 16'(w);
    end
    unitKind[0] = KIND_INTEGER;
    unitKind[1] = KIND_INTEGER;
    unitKind[2] = KIND_FLOAT;
    unitKind[3] = KIND_MEMORY;
    unitKind[4] = KIND_BRANCH;
    unitKind[5] = KIND_THREADIDX;
    idle();
    tick();
    tick();
    testReset();
    testSingle();
    testPriority();
    testMulti();
    testKinds();
    testBusy();
    testHold();
    testMixed();
    testArranger();
    summary();
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end
endmodule